// File: doc/BRIEF.md
# EPP Transfer Cycle Gate

This block sits between a host register bus and the byte-wide pins of an enhanced parallel port. Host accesses to the port's address-cycle slot (offset 3) and data-cycle slot (offset 4) are turned into strobed byte cycles on the peripheral side. A cycle only starts when the mode bits of the control register hold the exact pattern for that direction. Otherwise a write is dropped and a read returns all ones. The control register (offset 2) and the status register (offset 1) are also decoded here.

Each peripheral byte cycle raises an address or data strobe and holds it until the peripheral signals ready. If ready does not come within a programmable number of clocks, the cycle fails. A failure sets a sticky timeout flag, which the status register reports in bit 0 in place of the sampled pin. Writing the status register with bit 0 set clears the flag. Data-slot accesses of 1, 2 or 4 bytes are split into byte cycles, lowest byte first.

The host side is a valid/ready request with a one-cycle response pulse. `req_ready` is high only while no peripheral cycle is running, so back-pressure is applied for the whole length of a transfer. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `rsp_valid` cannot be stalled: the host must take `rsp_rdata` in the cycle it is shown.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset, `req_ready` is 1, both strobes are 0, a control read returns 0xCC in the low byte, and a status read shows bit 0 clear.
- R2: A control write stores the low byte with bits 7 and 6 forced to 1. A later control read returns that value in bits 7:0, with bits 31:8 all ones.
- R3: A write to offset 3 or 4 runs peripheral cycles only when (control AND 0x2F) equals 0x04. In any other case no strobe is raised, and the response comes the cycle after acceptance.
- R4: A read from offset 3 or 4 runs peripheral cycles only when (control AND 0x2F) equals 0x24. In any other case no strobe is raised, and `rsp_rdata` is 0xFFFFFFFF.
- R5: Offset 3 moves one byte on `per_addr_stb`. Offset 4 moves 1 byte for size 0, 2 bytes for size 1, and 4 bytes for sizes 2 and 3, on `per_data_stb`, lowest byte first. Each byte has its own strobe pulse, and the strobe drops in the cycle after ready is seen high. `per_write` is 1 for writes. Read bytes fill `rsp_rdata` from bit 0 upward, and bytes not transferred read as 0xFF.
- R6: A strobe with no ready for TIMEOUT_CYCLES consecutive clocks ends the byte as failed. The strobe is then dropped, the timeout flag is set, and the remaining bytes are skipped. Ready seen in the last allowed clock still counts as success.
- R7: A status read returns `per_status[7:1]` in bits 7:1 and the timeout flag in bit 0, with bits 31:8 all ones.
- R8: A status write with bit 0 = 1 clears the timeout flag. With bit 0 = 0 the flag is unchanged.
- R9: When address bit 10 is set (the extended-mode window), reads return 0xFFFFFFFF and writes change nothing. Offsets 0, 5, 6 and 7 behave the same way.
- R10: Each accepted request gets exactly one `rsp_valid` pulse. A request that runs no peripheral cycle answers one cycle after acceptance. While cycles run, `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request (no transfer running) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register offset in bits 2:0; bit 10 selects the extended-mode window |
| req_size | input | 2 | Data-slot access width: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | DATA_W | Write value |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read value, valid with rsp_valid |
| per_status | input | 8 | Status pins sampled by status reads |
| per_addr_stb | output | 1 | Address-cycle strobe |
| per_data_stb | output | 1 | Data-cycle strobe |
| per_write | output | 1 | Direction of the current byte cycle, 1 = to peripheral |
| per_wdata | output | 8 | Byte driven to the peripheral |
| per_rdata | input | 8 | Byte returned by the peripheral |
| per_ready | input | 1 | Peripheral ready/wait handshake |

## Verification
A mode decode error shows up in the same access. Strobes appear where none should, or a denied read returns something other than all ones. A lane index that is off by one shows up in the very first multi-byte transfer, as bytes in the wrong order on `per_wdata` or in `rsp_rdata`. A timeout counter that is wrong changes how long the strobe is held on a stalled byte. It also decides whether a ready arriving in the last allowed clock still passes. A timeout flag that is wrong in the set or clear path is only visible at the next status read, which is why the stimulus reads status often.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam logic [2:0] OFS_STATUS   = 3'd1;
  localparam logic [2:0] OFS_CONTROL  = 3'd2;
  localparam logic [2:0] OFS_EPP_ADDR = 3'd3;
  localparam logic [2:0] OFS_EPP_DATA = 3'd4;

  localparam logic [7:0] MODE_MASK   = 8'h2F;
  localparam logic [7:0] WR_PATTERN  = 8'h04;
  localparam logic [7:0] RD_PATTERN  = 8'h24;
  localparam logic [7:0] CTRL_FORCED = 8'hC0;
  localparam logic [7:0] CTRL_RESET  = 8'hCC;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_STROBE, SEQ_GAP} seq_state_e;

  function automatic int size_to_bytes(input logic [1:0] sz, input int lanes);
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    return (n > lanes) ? lanes : n;
  endfunction
endpackage

// File: rtl/epp_mode_check.sv
module epp_mode_check
  import epp_gate_pkg::*;
(
  input  logic [7:0] ctrl,
  output logic       wr_ok,
  output logic       rd_ok
);
  logic [7:0] mode_bits;
  assign mode_bits = ctrl & MODE_MASK;
  assign wr_ok = (mode_bits == WR_PATTERN);
  assign rd_ok = (mode_bits == RD_PATTERN);
endmodule

// File: rtl/epp_ctrl_regs.sv
module epp_ctrl_regs
  import epp_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       flag_clr,
  input  logic       flag_set,
  output logic [7:0] ctrl_q,
  output logic       tmo_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      tmo_flag <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata | CTRL_FORCED;
      if (flag_set)      tmo_flag <= 1'b1;
      else if (flag_clr) tmo_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/epp_byte_sequencer.sv
module epp_byte_sequencer
  import epp_gate_pkg::*;
#(
  parameter  int DATA_W         = 32,
  parameter  int TIMEOUT_CYCLES = 16,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int NB_W  = $clog2(LANES + 1),
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_addr,
  input  logic              start_write,
  input  logic [NB_W-1:0]   start_nbytes,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              per_ready,
  input  logic [7:0]        per_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [DATA_W-1:0] rdata,
  output logic              addr_stb,
  output logic              data_stb,
  output logic              per_write,
  output logic [7:0]        per_wdata
);
  seq_state_e              state_q;
  logic [IDX_W-1:0]        idx_q;
  logic [NB_W-1:0]         nb_q;
  logic                    addr_q, wr_q, done_q, fail_q;
  logic [LANES-1:0][7:0]   wbuf_q, acc_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    last_byte, expired;

  assign last_byte = (NB_W'(idx_q) + NB_W'(1)) == nb_q;
  assign expired   = (cnt_q == CNT_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      nb_q    <= '0;
      addr_q  <= 1'b0;
      wr_q    <= 1'b0;
      wbuf_q  <= '0;
      acc_q   <= '1;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_STROBE;
          idx_q   <= '0;
          nb_q    <= start_nbytes;
          addr_q  <= start_addr;
          wr_q    <= start_write;
          wbuf_q  <= start_wdata;
          acc_q   <= '1;
          cnt_q   <= '0;
        end
        SEQ_STROBE: begin
          if (per_ready) begin
            if (!wr_q) acc_q[idx_q] <= per_rdata;
            cnt_q <= '0;
            if (last_byte) begin
              done_q  <= 1'b1;
              state_q <= SEQ_IDLE;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= SEQ_GAP;
            end
          end else if (expired) begin
            fail_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= SEQ_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        SEQ_GAP: state_q <= SEQ_STROBE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != SEQ_IDLE);
  assign addr_stb  = (state_q == SEQ_STROBE) && addr_q;
  assign data_stb  = (state_q == SEQ_STROBE) && !addr_q;
  assign per_write = wr_q;
  assign per_wdata = wbuf_q[idx_q];
  assign rdata     = acc_q;
  assign done      = done_q;
  assign fail      = fail_q;
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter  int ADDR_W         = 11,
  parameter  int DATA_W         = 32,
  parameter  int TIMEOUT_CYCLES = 16,
  parameter  int ECP_BIT        = 10,
  localparam int LANES = DATA_W / 8,
  localparam int NB_W  = $clog2(LANES + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [7:0]        per_status,
  output logic              per_addr_stb,
  output logic              per_data_stb,
  output logic              per_write,
  output logic [7:0]        per_wdata,
  input  logic [7:0]        per_rdata,
  input  logic              per_ready
);
  logic [7:0]        ctrl_q;
  logic              tmo_flag, wr_ok, rd_ok;
  logic              seq_busy, seq_done, seq_fail;
  logic [DATA_W-1:0] seq_rdata;
  logic              accept, in_ecp, epp_slot, go;
  logic [2:0]        ofs;
  logic [NB_W-1:0]   nbytes;
  logic              reg_done_q;
  logic [DATA_W-1:0] reg_rdata_d, reg_rdata_q;

  assign accept   = req_valid && req_ready;
  assign in_ecp   = req_addr[ECP_BIT];
  assign ofs      = req_addr[2:0];
  assign epp_slot = !in_ecp && (ofs == OFS_EPP_ADDR || ofs == OFS_EPP_DATA);
  assign go       = accept && epp_slot && (req_write ? wr_ok : rd_ok);
  assign nbytes   = (ofs == OFS_EPP_ADDR) ? NB_W'(1)
                                          : NB_W'(size_to_bytes(req_size, LANES));

  epp_mode_check u_mode (.ctrl(ctrl_q), .wr_ok(wr_ok), .rd_ok(rd_ok));

  epp_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(accept && req_write && !in_ecp && ofs == OFS_CONTROL),
    .ctrl_wdata(req_wdata[7:0]),
    .flag_clr(accept && req_write && !in_ecp && ofs == OFS_STATUS && req_wdata[0]),
    .flag_set(seq_fail),
    .ctrl_q(ctrl_q), .tmo_flag(tmo_flag)
  );

  epp_byte_sequencer #(.DATA_W(DATA_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(go), .start_addr(ofs == OFS_EPP_ADDR), .start_write(req_write),
    .start_nbytes(nbytes), .start_wdata(req_wdata),
    .per_ready(per_ready), .per_rdata(per_rdata),
    .busy(seq_busy), .done(seq_done), .fail(seq_fail), .rdata(seq_rdata),
    .addr_stb(per_addr_stb), .data_stb(per_data_stb),
    .per_write(per_write), .per_wdata(per_wdata)
  );

  always_comb begin
    reg_rdata_d = '1;
    if (!in_ecp && !req_write) begin
      if (ofs == OFS_STATUS)       reg_rdata_d[7:0] = {per_status[7:1], tmo_flag};
      else if (ofs == OFS_CONTROL) reg_rdata_d[7:0] = ctrl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_done_q  <= 1'b0;
      reg_rdata_q <= '1;
    end else begin
      reg_done_q  <= accept && !go;
      reg_rdata_q <= reg_rdata_d;
    end
  end

  assign req_ready = !seq_busy;
  assign rsp_valid = reg_done_q || seq_done;
  assign rsp_rdata = seq_done ? seq_rdata : reg_rdata_q;
endmodule

// File: rtl/epp_gate_checker.sv
module epp_gate_checker #(
  parameter int ADDR_W         = 11,
  parameter int TIMEOUT_CYCLES = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              per_addr_stb,
  input logic              per_data_stb,
  input logic              per_ready
);
  logic        stb;
  logic [31:0] stb_run;
  assign stb = per_addr_stb || per_data_stb;

  always_ff @(posedge clk) begin
    if (!rst_n)   stb_run <= '0;
    else if (stb) stb_run <= stb_run + 32'd1;
    else          stb_run <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_addr_stb && per_data_stb)); // R5
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> !req_ready); // R10
  AST_READY_ENDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && per_ready) |=> !stb); // R5
  AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stb_run <= 32'(TIMEOUT_CYCLES)); // R6
  AST_REG_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[2:0] != 3'd3 && req_addr[2:0] != 3'd4)
      |=> rsp_valid); // R10
endmodule

bind epp_cycle_gate epp_gate_checker #(.ADDR_W(ADDR_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .per_addr_stb(per_addr_stb),
  .per_data_stb(per_data_stb), .per_ready(per_ready)
);

// File: tb/epp_cycle_gate_test.sv
module epp_cycle_gate_test;
  localparam int TMO = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  per_status = 8'hFF;
  logic        per_addr_stb, per_data_stb, per_write;
  logic [7:0]  per_wdata;
  logic [7:0]  per_rdata = '0;
  logic        per_ready = 1'b0;

  int n_chk = 0, n_fail = 0;
  int hold = 0, k = 0, lat = 0, fail_at = 9, log_n = 0, last_hold = 0;
  logic [7:0] log_b [8];
  logic       log_a [8];
  logic       log_w [8];
  logic [7:0] rd_pat [4];
  logic [7:0] ctrl_m = 8'hCC;
  logic       flag_m = 1'b0;
  int         rsp_wait;
  logic       ready_after;

  always #4 clk = ~clk;

  epp_cycle_gate #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .per_status(per_status), .per_addr_stb(per_addr_stb), .per_data_stb(per_data_stb),
    .per_write(per_write), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .per_ready(per_ready)
  );

  // peripheral model: ready after lat+1 strobe clocks, never for byte fail_at
  always @(negedge clk) begin
    if (per_addr_stb || per_data_stb) begin
      hold = hold + 1;
      last_hold = hold;
      if (k != fail_at && hold > lat && k < 4 && log_n < 8) begin
        per_ready = 1'b1;
        per_rdata = rd_pat[k];
        log_b[log_n] = per_wdata;
        log_a[log_n] = per_addr_stb;
        log_w[log_n] = per_write;
        log_n = log_n + 1;
        k = k + 1;
      end else per_ready = 1'b0;
    end else begin
      hold = 0;
      per_ready = 1'b0;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [10:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    log_n = 0; k = 0;
    chk("R10 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    ready_after = req_ready;
    rsp_wait = 1;
    while (!rsp_valid && rsp_wait < 200) begin
      @(negedge clk);
      rsp_wait++;
    end
    if (!rsp_valid) chk("R10 response missing", 32'd0, 32'd1);
    rd = rsp_rdata;
  endtask

  task automatic run_op(input logic wr, input logic [10:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd);
    logic [31:0] rd, exp;
    logic [2:0]  ofs;
    logic        ecp, epp, runs;
    int          nb, done_n;
    for (int i = 0; i < 4; i++) rd_pat[i] = 8'($urandom);
    per_status = 8'($urandom);
    access(wr, addr, sz, wd, rd);
    ofs = addr[2:0];
    ecp = addr[10];
    epp = !ecp && (ofs == 3'd3 || ofs == 3'd4);
    if (epp) begin
      nb = (ofs == 3'd3) ? 1 : (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      runs = wr ? ((ctrl_m & 8'h2F) == 8'h04) : ((ctrl_m & 8'h2F) == 8'h24);
      done_n = runs ? ((fail_at < nb) ? fail_at : nb) : 0;
      chk(wr ? "R3 byte count" : "R4 byte count", 32'(log_n), 32'(done_n));
      if (!runs) chk("R10 immediate response", 32'(rsp_wait), 32'd1);
      else chk("R10 busy during transfer", {31'd0, ready_after}, 32'd0);
      for (int i = 0; i < done_n && i < log_n; i++) begin
        chk("R5 strobe kind and direction", {30'd0, log_a[i], log_w[i]},
            {30'd0, (ofs == 3'd3), wr});
        if (wr) chk("R5 byte order", {24'd0, log_b[i]}, {24'd0, wd[8*i +: 8]});
      end
      if (!wr) begin
        exp = '1;
        for (int i = 0; i < done_n; i++) exp[8*i +: 8] = rd_pat[i];
        chk(runs ? "R5 read assembly" : "R4 denied read", rd, exp);
      end
      if (runs && fail_at < nb) begin
        flag_m = 1'b1;
        chk("R6 strobe held to limit", 32'(last_hold), 32'(TMO));
      end
    end else begin
      chk("R10 register response latency", 32'(rsp_wait), 32'd1);
      if (ecp || !(ofs == 3'd1 || ofs == 3'd2)) begin
        if (!wr) chk("R9 inert read", rd, 32'hFFFFFFFF);
      end else if (ofs == 3'd1) begin
        if (wr) begin if (wd[0]) flag_m = 1'b0; end
        else chk("R7 status read", rd, {24'hFFFFFF, per_status[7:1], flag_m});
      end else begin
        if (wr) ctrl_m = wd[7:0] | 8'hC0;
        else chk("R2 control read", rd, {24'hFFFFFF, ctrl_m});
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r;
    logic [7:0] cv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 strobes idle", {30'd0, per_addr_stb, per_data_stb}, 32'd0);
    chk("R1 no response", {31'd0, rsp_valid}, 32'd0);
    run_op(1'b0, 11'd2, 2'd0, 32'd0);                 // R1 control 0xCC
    run_op(1'b0, 11'd1, 2'd0, 32'd0);                 // R1 flag clear
    lat = 0; fail_at = 9;
    run_op(1'b1, 11'd4, 2'd2, 32'h11223344);          // R3 denied in reset mode
    run_op(1'b1, 11'd2, 2'd0, 32'h00000004);          // R2
    run_op(1'b0, 11'd2, 2'd0, 32'd0);
    run_op(1'b1, 11'd4, 2'd2, 32'h11223344);          // R5 four bytes
    run_op(1'b1, 11'd3, 2'd2, 32'h000000A5);          // R5 address one byte
    run_op(1'b0, 11'd4, 2'd0, 32'd0);                 // R4 read denied in write mode
    run_op(1'b1, 11'd2, 2'd0, 32'h00000024);
    run_op(1'b0, 11'd4, 2'd1, 32'd0);                 // R5 two-byte read
    run_op(1'b0, 11'd3, 2'd2, 32'd0);                 // R5 address read one byte
    run_op(1'b1, 11'd4, 2'd0, 32'h5A);                // R3 write denied in read mode
    lat = TMO - 1;
    run_op(1'b0, 11'd4, 2'd2, 32'd0);                 // R6 ready in last clock
    run_op(1'b0, 11'd1, 2'd0, 32'd0);                 // R7 flag still clear
    lat = 0; fail_at = 2;
    run_op(1'b0, 11'd4, 2'd2, 32'd0);                 // R6 fail on byte 2
    run_op(1'b0, 11'd1, 2'd0, 32'd0);                 // R7 flag set
    run_op(1'b1, 11'd1, 2'd0, 32'hFE);                // R8 bit0 = 0 keeps flag
    run_op(1'b0, 11'd1, 2'd0, 32'd0);
    run_op(1'b1, 11'd1, 2'd0, 32'h01);                // R8 clear
    run_op(1'b0, 11'd1, 2'd0, 32'd0);
    fail_at = 9;
    run_op(1'b0, 11'h403, 2'd0, 32'd0);               // R9 window read
    run_op(1'b1, 11'h402, 2'd0, 32'h00);              // R9 window write ignored
    run_op(1'b0, 11'd2, 2'd0, 32'd0);
    run_op(1'b1, 11'd2, 2'd0, 32'h2C);                // R3 extra bit set
    run_op(1'b1, 11'd4, 2'd0, 32'h77);
    run_op(1'b1, 11'd2, 2'd0, 32'h05);
    run_op(1'b1, 11'd4, 2'd0, 32'h77);
    for (int n = 0; n < 250; n++) begin
      r = int'($urandom % 10);
      lat = int'($urandom % TMO);
      fail_at = ($urandom % 4 == 0) ? int'($urandom % 4) : 9;
      case (r)
        0: begin
          cv = ($urandom % 3 == 0) ? 8'($urandom) : (($urandom % 2 == 0) ? 8'h04 : 8'h24);
          run_op(1'b1, 11'd2, 2'd0, {24'($urandom), cv});
        end
        1: run_op(1'b0, 11'd2, 2'd0, 32'd0);
        2: run_op(1'b0, 11'd1, 2'd0, 32'd0);
        3: run_op(1'b1, 11'd1, 2'd0, $urandom);
        8: run_op(1'($urandom), 11'h400 | 11'($urandom % 8), 2'd0, $urandom);
        9: run_op(1'($urandom), ($urandom % 2 == 0) ? 11'd0 : 11'(5 + $urandom % 3), 2'd0, $urandom);
        default: run_op(1'($urandom), ($urandom % 2 == 0) ? 11'd3 : 11'd4, 2'($urandom), $urandom);
      endcase
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule